// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous static memory whose bus never needs an idle cycle when it turns from reads to writes or back. A command (address, read/write select, byte enables) is taken at one clock edge. The write data for that command arrives one or two edges later, depending on the timing mode. Because the write data lags its address, a read issued on the very next clock can target a word whose write is still in flight. The core then merges the in-flight bytes into the read result, so reads and writes can alternate on every clock.

A static mode input chooses between two timings. In flow-through mode, read data appears combinationally in the cycle after the command and write data is taken one edge after the command. In pipelined mode, read data is registered and appears one cycle later, and write data is taken two edges after the command. A load cycle opens a four-beat burst. Advance cycles then step through the burst in linear or interleaved order. Every byte is nine bits wide and is parity-checked when its data is taken. A sleep input freezes command intake but keeps the stored contents. The mode may only be changed after at least three idle cycles.

Top module: `lw_sram`

## Requirements
- R1: A load cycle is accepted only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. A load with any enable outside that state is a deselect: the memory is not changed, no read result appears, and any open burst is closed.
- R2: With `pipe_mode`=0, a read accepted at edge k gives `rd_valid`=1 and the word on `rd_data` in the cycle between edges k and k+1. A write accepted at edge k stores the `wr_data` present at edge k+1.
- R3: With `pipe_mode`=1, a read accepted at edge k gives its result in the cycle between edges k+1 and k+2. A write accepted at edge k stores the `wr_data` present at edge k+2.
- R4: A read returns the stored word, including every write whose data edge is at or before the read's result edge (edge k in flow-through mode, edge k+1 in pipelined mode).
- R5: Reads and writes may be issued on consecutive edges in any mix. A read of a word whose write data arrives on the read's result edge returns those incoming bytes for the enabled bytes and the stored bytes for the others.
- R6: Byte i occupies bits 9i+8..9i. `bw_n[i]`=0 enables byte i for a write; bytes with `bw_n[i]`=1 keep their old contents. Byte enables are sampled with the command.
- R7: A load (`adv`=0) with `ilv_order`=0 opens a linear burst. Each following advance cycle (`adv`=1) repeats the load's operation at the address whose upper bits are those of the load address and whose two low bits are (start + beat) mod 4. The beat count goes 1, 2, 3, then wraps.
- R8: A load with `ilv_order`=1 opens an interleaved burst. On an advance cycle the two low address bits are the start bits XOR the beat count.
- R9: `par_err` is 1 for exactly the cycle after a write's data edge if any enabled byte has the wrong parity. With `odd_par`=0, the XOR of all 9 bits must be 0; with `odd_par`=1, it must be 1. Disabled bytes are not checked, and the data is stored regardless.
- R10: While `sleep`=1, every command is ignored and any open burst is closed. The contents are kept, and writes already accepted still take their data.
- R11: `rd_data` is all zeros in every cycle in which `rd_valid` is 0.
- R12: After reset, `rd_valid`=0, `par_err`=0, and no burst is open, so an advance cycle does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_mode | input | 1 | 1 = pipelined timing, 0 = flow-through timing |
| sleep | input | 1 | Power-down: ignore commands |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles) |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| ilv_order | input | 1 | Burst order at load: 1 = interleaved, 0 = linear |
| bw_n | input | NB | Per-byte write enables, active low |
| addr | input | AW | Word address |
| wr_data | input | NB*BW | Late write data |
| odd_par | input | 1 | Parity sense: 1 = odd, 0 = even |
| rd_data | output | NB*BW | Read data, zero when not valid |
| rd_valid | output | 1 | Read data valid |
| par_err | output | 1 | Parity error on the write data just taken |

## Verification
A command stage that holds the wrong address or operation shows up as a wrong `rd_data` word or a missing `rd_valid` on the read's own result cycle: one cycle after the command in flow-through mode, two in pipelined mode. A write stored on the wrong edge, or with the wrong byte mask, stays hidden until that word is read again. The bench therefore reads back every address it writes, and it reads right behind writes to the same word so that a forwarding fault shows on the very next result. A burst counter that is off by one beat corrupts a neighbouring word inside the same four-word block. This is visible as soon as that word is read.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pipe_mode,
  input  logic                 sleep,
  input  logic                 en_a_n,
  input  logic                 en_b,
  input  logic                 en_c_n,
  input  logic                 wr_n,
  input  logic                 adv,
  input  logic                 ilv_order,
  input  logic [NB-1:0]        bw_n,
  input  logic [AW-1:0]        addr,
  input  logic [NB*BW-1:0]     wr_data,
  input  logic                 odd_par,
  output logic [NB*BW-1:0]     rd_data,
  output logic                 rd_valid,
  output logic                 par_err
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          b_open, b_ilv, b_wr;
  logic [AW-1:0] b_addr;
  logic [1:0]    b_beat;

  logic          v1, w1, v2, w2;
  logic [AW-1:0] a1, a2;
  logic [NB-1:0] be1, be2;

  logic [NB-1:0] bad;
  logic [DW-1:0] merged, prd;
  logic          prv;

  wire          sel   = !en_a_n && en_b && !en_c_n;
  wire          ld    = !sleep && !adv && sel;
  wire          ad    = !sleep && adv && b_open;
  wire [1:0]    nbeat = b_beat + 2'd1;
  wire [1:0]    lo    = b_ilv ? (b_addr[1:0] ^ nbeat) : (b_addr[1:0] + nbeat);
  wire [AW-1:0] c_addr = ld ? addr : {b_addr[AW-1:2], lo};
  wire          c_wr   = ld ? !wr_n : b_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_open <= 1'b0;
      b_ilv  <= 1'b0;
      b_wr   <= 1'b0;
      b_addr <= '0;
      b_beat <= '0;
    end else if (sleep) begin
      b_open <= 1'b0;
    end else if (!adv) begin
      b_open <= sel;
      if (sel) begin
        b_addr <= addr;
        b_ilv  <= ilv_order;
        b_wr   <= !wr_n;
        b_beat <= '0;
      end
    end else if (b_open) begin
      b_beat <= nbeat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; w1 <= 1'b0; a1 <= '0; be1 <= '0;
      v2 <= 1'b0; w2 <= 1'b0; a2 <= '0; be2 <= '0;
    end else begin
      v1 <= ld || ad; w1 <= c_wr; a1 <= c_addr; be1 <= ~bw_n;
      v2 <= v1;       w2 <= w1;   a2 <= a1;     be2 <= be1;
    end
  end

  wire          cw  = pipe_mode ? (v2 && w2) : (v1 && w1);
  wire [AW-1:0] ca  = pipe_mode ? a2 : a1;
  wire [NB-1:0] cbe = pipe_mode ? be2 : be1;

  always_ff @(posedge clk) begin
    if (cw)
      for (int i = 0; i < NB; i++)
        if (cbe[i]) mem[ca][i*BW +: BW] <= wr_data[i*BW +: BW];
  end

  always_comb begin
    for (int i = 0; i < NB; i++) bad[i] = (^wr_data[i*BW +: BW]) ^ odd_par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_err <= 1'b0;
    else        par_err <= cw && |(cbe & bad);
  end

  wire rd_hit = v1 && !w1;
  wire fwd    = pipe_mode && v2 && w2 && (a2 == a1);

  always_comb begin
    merged = mem[a1];
    for (int i = 0; i < NB; i++)
      if (fwd && be2[i]) merged[i*BW +: BW] = wr_data[i*BW +: BW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv <= 1'b0;
      prd <= '0;
    end else begin
      prv <= rd_hit;
      prd <= rd_hit ? merged : '0;
    end
  end

  assign rd_valid = pipe_mode ? prv : rd_hit;
  assign rd_data  = pipe_mode ? prd : (rd_hit ? merged : '0);

  a_r11_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);
  a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !v1);
  a_r9_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(cw));
  a_r3_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd_valid) |-> $past(v1 && !w1));
  a_r7_burst_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    ad |=> (a1[AW-1:2] == $past(b_addr[AW-1:2])));
endmodule

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;
  localparam int AW = 6, NB = 4, BW = 9, DW = NB * BW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, pipe_mode, sleep, en_a_n, en_b, en_c_n, wr_n, adv, ilv_order, odd_par;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data, rd_data;
  logic rd_valid, par_err;

  lw_sram #(.AW(AW), .NB(NB), .BW(BW)) dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sleep(sleep),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .wr_n(wr_n), .adv(adv),
    .ilv_order(ilv_order), .bw_n(bw_n), .addr(addr), .wr_data(wr_data),
    .odd_par(odd_par), .rd_data(rd_data), .rd_valid(rd_valid), .par_err(par_err));

  int checks = 0, errors = 0;
  string cur = "R12";
  bit armed = 0;

  // behavioural reference model
  logic [DW-1:0] m [1<<AW];
  bit hv [4], hw [4];
  logic [AW-1:0] ha [4];
  logic [NB-1:0] hb [4];
  bit mo, mi, mwr;
  logic [AW-1:0] mad;
  int mbeat = 0, ecount = 0;
  bit exp_v, exp_p;
  logic [DW-1:0] exp_d;
  logic [DW-1:0] wd_ring [8];

  bit cv, cwr, sok;
  logic [AW-1:0] cad;
  logic [1:0] lo2;
  int n, lat, j, r;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hv[i] = 0;
      mo = 0; exp_v = 0; exp_d = '0; exp_p = 0; ecount = 0;
    end else begin
      n = ecount; lat = pipe_mode ? 2 : 1;
      sok = !en_a_n && en_b && !en_c_n;
      cv = 0; cwr = 0; cad = '0;
      if (sleep) mo = 0;
      else if (!adv) begin
        if (sok) begin
          cv = 1; cwr = !wr_n; cad = addr;
          mo = 1; mi = ilv_order; mwr = !wr_n; mad = addr; mbeat = 0;
        end else mo = 0;
      end else if (mo) begin
        mbeat = (mbeat + 1) % 4;
        lo2 = mi ? (mad[1:0] ^ 2'(mbeat)) : 2'(mad[1:0] + mbeat);
        cad = {mad[AW-1:2], lo2}; cv = 1; cwr = mwr;
      end
      hv[n%4] = cv; hw[n%4] = cwr; ha[n%4] = cad; hb[n%4] = ~bw_n;
      j = (n + 4 - lat) % 4;
      exp_p = 0;
      if (hv[j] && hw[j])
        for (int i = 0; i < NB; i++)
          if (hb[j][i]) begin
            m[ha[j]][i*BW +: BW] = wr_data[i*BW +: BW];
            if ((^wr_data[i*BW +: BW]) ^ odd_par) exp_p = 1;
          end
      r = (n + 5 - lat) % 4;
      exp_v = hv[r] && !hw[r];
      exp_d = exp_v ? m[ha[r]] : '0;
      ecount++;
    end
  end

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (edge %0d)", cur, what, act, exp, ecount);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && armed) begin
      chk("rd_valid", DW'(rd_valid), DW'(exp_v));
      chk("rd_data", rd_data, exp_d);
      chk("par_err", DW'(par_err), DW'(exp_p));
    end
  end

  function automatic logic [DW-1:0] rnd();
    logic [63:0] t;
    t = {$urandom, $urandom};
    return t[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] gp(input logic [DW-1:0] raw, input bit odd);
    logic [DW-1:0] o;
    for (int i = 0; i < NB; i++)
      o[i*BW +: BW] = {(^raw[i*BW +: BW-1]) ^ odd, raw[i*BW +: BW-1]};
    return o;
  endfunction

  // bad_ce: 0 = selected, 1..3 = that enable inactive
  task automatic step(input int bad_ce, input bit w_n, input bit a, input bit il,
                      input logic [NB-1:0] be_n, input logic [AW-1:0] ad,
                      input logic [DW-1:0] d, input bit has_wd, input bit sl);
    int k, l;
    @(negedge clk); #2;
    k = ecount; l = pipe_mode ? 2 : 1;
    if (has_wd) wd_ring[(k+l)%8] = d;
    wr_data = wd_ring[k%8];
    wd_ring[k%8] = rnd();
    en_a_n = (bad_ce == 1); en_b = (bad_ce != 2); en_c_n = (bad_ce == 3);
    wr_n = w_n; adv = a; ilv_order = il; bw_n = be_n; addr = ad; sleep = sl;
  endtask

  task automatic wr(input logic [AW-1:0] ad, input logic [DW-1:0] d, input logic [NB-1:0] be_n);
    step(0, 0, 0, 0, be_n, ad, d, 1, 0);
  endtask
  task automatic rd(input logic [AW-1:0] ad);
    step(0, 1, 0, 0, '1, ad, '0, 0, 0);
  endtask
  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) step(1, 1, 0, 0, '1, '0, '0, 0, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) wd_ring[i] = rnd();
    rst_n = 0; pipe_mode = 0; sleep = 0; en_a_n = 1; en_b = 0; en_c_n = 1;
    wr_n = 1; adv = 0; ilv_order = 0; odd_par = 0; bw_n = '1; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    cur = "R12";
    chk("reset rd_valid", DW'(rd_valid), '0);
    chk("reset par_err", DW'(par_err), '0);
    armed = 1;
    step(0, 1, 1, 0, '1, 6'd3, '0, 0, 0);  // R12: advance with no open burst
    idle(3);

    for (int md = 0; md < 2; md++) begin
      pipe_mode = md[0];
      idle(3);
      cur = "R4";
      for (int a = 0; a < 64; a++) wr(6'(a), gp(rnd(), 0), '0);
      cur = md ? "R3" : "R2";
      for (int a = 0; a < 64; a++) rd(6'(a));
      idle(3);
      cur = "R5";
      for (int i = 0; i < 150; i++) begin
        logic [AW-1:0] ra;
        ra = 6'($urandom_range(0, 7));
        if ($urandom_range(0, 1)) wr(ra, gp(rnd(), 0), 4'($urandom_range(0, 3) == 0 ? $urandom : 0));
        else rd(ra);
      end
      wr(6'd4, gp(rnd(), 0), '0); rd(6'd4); rd(6'd4); wr(6'd4, gp(rnd(), 0), '0); rd(6'd4);
      idle(3);
      cur = "R6";
      wr(6'd10, gp(rnd(), 0), 4'b1010); rd(6'd10);
      wr(6'd10, gp(rnd(), 0), 4'b0111); idle(2); rd(6'd10);
      idle(3);
      cur = "R7";
      step(0, 0, 0, 0, '0, 6'd13, gp(rnd(), 0), 1, 0);
      for (int b = 0; b < 3; b++) step(0, 1, 1, 1, '0, 6'd0, gp(rnd(), 0), 1, 0);
      step(0, 1, 0, 0, '1, 6'd13, '0, 0, 0);
      for (int b = 0; b < 6; b++) step(0, 0, 1, 1, '1, 6'd0, '0, 0, 0);
      idle(3);
      cur = "R8";
      step(0, 0, 0, 1, '0, 6'd22, gp(rnd(), 0), 1, 0);
      for (int b = 0; b < 3; b++) step(0, 1, 1, 0, '0, 6'd0, gp(rnd(), 0), 1, 0);
      step(0, 1, 0, 1, '1, 6'd23, '0, 0, 0);
      for (int b = 0; b < 4; b++) step(0, 0, 1, 0, '1, 6'd0, '0, 0, 0);
      for (int a = 20; a < 24; a++) rd(6'(a));
      idle(3);
      cur = "R9";
      begin
        logic [DW-1:0] g;
        g = gp(rnd(), 0); g[2*BW] = ~g[2*BW];
        wr(6'd40, g, '0); rd(6'd40);
        wr(6'd41, g, 4'b0100); rd(6'd41);
        idle(3);
        odd_par = 1;
        idle(3);
        wr(6'd42, gp(rnd(), 0), '0); wr(6'd43, gp(rnd(), 1), '0);
        rd(6'd42); rd(6'd43);
        idle(3);
        odd_par = 0;
        idle(3);
      end
      cur = "R1";
      for (int b = 1; b < 4; b++) begin
        step(b, 0, 0, 0, '0, 6'd30, gp(rnd(), 0), 0, 0);
        rd(6'd30);
      end
      step(0, 1, 0, 0, '1, 6'd28, '0, 0, 0);
      step(2, 1, 0, 0, '1, 6'd28, '0, 0, 0);
      step(0, 1, 1, 0, '1, 6'd0, '0, 0, 0);
      idle(3);
      cur = "R10";
      wr(6'd31, gp(rnd(), 0), '0);
      step(0, 0, 0, 0, '0, 6'd31, gp(rnd(), 0), 1, 1);
      step(0, 1, 0, 0, '1, 6'd31, '0, 0, 1);
      step(0, 0, 0, 0, '0, 6'd32, gp(rnd(), 0), 0, 1);
      step(0, 1, 0, 0, '1, 6'd32, '0, 0, 0);
      step(0, 1, 1, 0, '1, 6'd0, '0, 0, 1);
      step(0, 1, 1, 0, '1, 6'd0, '0, 0, 0);
      rd(6'd31); rd(6'd32); rd(6'd33);
      cur = "R11";
      idle(5);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule